// File: doc/BRIEF.md
# First-Hit Channel Address Serializer

This block watches 64 per-channel threshold-crossing lines and reports which channel fired first in an event. It sends the answer to an external trigger system on two wires clocked by a dedicated fast clock (nominally 160 MHz). A marker pulse goes out on one wire, then the winning channel's 6-bit number follows bit by bit on the other. An event's position is therefore known a few nanoseconds after the first hit, without waiting for any readout.

Each hit line is sampled on the rising edge of the fast clock. A frame starts only when a line goes from low to high between two consecutive samples. When several channels rise in the same sample, the lowest channel number is sent. While a frame is on the wires, further rising hits are discarded. The block then returns to idle, ready for the next event. A mode input selects one of two shift modes. In single-edge mode one bit is sent per clock cycle. In dual-edge mode one bit is sent per clock phase: the high half first, then the low half. The mode is captured when each frame starts.

Top module: `first_hit_serializer`

## Requirements
- R1: After a synchronous reset, with `rst_n` low at a rising edge, and whenever no frame is in progress, `flag_out` and `addr_ser` are both low in both clock phases.
- R2: Suppose the earliest rising hit is first seen high at sampling edge S. Then the frame begins in the clock cycle that starts at edge S+1.
- R3: The address sent is the winning channel number in plain binary. It is sent most significant bit first: D5, D4, D3, D2, D1, D0.
- R4: When several channels are first seen high at the same sampling edge, the lowest channel number is sent.
- R5: Single-edge mode (`dual_edge` = 0) lasts exactly seven cycles:
  - In cycle 1, `flag_out` is high and `addr_ser` is low.
  - In cycles 2 to 7, `flag_out` is low and `addr_ser` carries D5 through D0, one bit per cycle.
  - Both lines are low in the cycle that follows.
- R6: Dual-edge mode (`dual_edge` = 1) lasts exactly four cycles:
  - `flag_out` is high only in the high phase of cycle 1.
  - `addr_ser` carries D5 in the low phase of cycle 1, D4 and D3 in cycle 2, D2 and D1 in cycle 3, and D0 in the high phase of cycle 4.
  - In the low phase of cycle 4, both lines are low.
- R7: Only a low-to-high change between consecutive samples starts a frame. A line that is held high never starts a second frame. A line that falls and rises again does start one.
- R8: Take a frame started by a hit first seen at edge S, with a frame length of L cycles (7 or 4). A rising hit first seen at any edge from S+1 through S+L is discarded. It is never reported, and it does not alter the address being sent.
- R9: A rising hit first seen at edge S+L+1 or later starts a new frame, following R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Dedicated serializer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dual_edge | input | 1 | 0: one bit per cycle, 1: one bit per clock phase; captured at frame start |
| chan_hit | input | 64 | Per-channel threshold-crossing lines, bit n is channel n |
| flag_out | output | 1 | Frame marker, high for one bit period |
| addr_ser | output | 1 | Serial channel address, MSB first |

## Verification
The assertions take three things for granted:
- The hit lines are already synchronous to the fast clock.
- `dual_edge` is steady around the sampling edge that starts a frame.
- The output properties are sampled at the rising edge, so in dual-edge mode they see only the high-phase bit.

The stimulus respects all three. It changes hits and mode one time unit after a rising edge, never near a sampling edge. It reads the serial lines at a quarter and three quarters of the clock period, which places each read in the middle of a phase. The extra hits used for the discard window are placed at exactly the last discarded edge and at the first accepted edge, in both modes.

// File: rtl/fhs_pkg.sv
// Package: shared sizing for the first-hit serializer.
// Assumes the channel count is a power of two or less; address width derives from it.
package fhs_pkg;
    parameter int CH_COUNT = 64;
    localparam int ADDR_W  = $clog2(CH_COUNT);
endpackage

// File: rtl/fhs_edge_capture.sv
// Module: fhs_edge_capture
// Samples the hit lines on the fast clock and flags lines that went low-to-high
// between two consecutive samples. Assumes hit lines are synchronous to clk.
module fhs_edge_capture #(
    parameter int CH = fhs_pkg::CH_COUNT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] hit_in,
    output logic [CH-1:0] rise
);
    logic [CH-1:0] samp_q;
    logic [CH-1:0] prev_q;

    // Two-stage sampling history of every hit line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            prev_q <= '0;
        end else begin
            samp_q <= hit_in;
            prev_q <= samp_q;
        end
    end

    // Per-channel new-hit detection.
    genvar g;
    generate
        for (g = 0; g < CH; g++) begin : g_rise
            assign rise[g] = samp_q[g] & ~prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/fhs_first_pick.sv
// Module: fhs_first_pick
// Combinational priority selector: returns the lowest-numbered set request.
// Assumes at most CH requests; the index is meaningless when valid is low.
module fhs_first_pick #(
    parameter int CH = fhs_pkg::CH_COUNT,
    localparam int AW = $clog2(CH)
) (
    input  logic [CH-1:0] req,
    output logic          valid,
    output logic [AW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = CH - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/fhs_frame_tx.sv
// Module: fhs_frame_tx
// Frame sequencer. It sends a flag slot, then the address bits MSB first.
// Single-edge mode sends one slot per cycle. Dual-edge mode sends two slots per
// cycle: the high phase first, then the low phase.
// Assumes start pulses last one cycle. While a frame is in progress, start is ignored.
module fhs_frame_tx #(
    parameter int AW = fhs_pkg::ADDR_W,
    localparam int LAST_SLOT = AW,
    localparam int SLOT_W    = $clog2(AW + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          dual_in,
    output logic          busy,
    output logic          dual_q,
    output logic [AW-1:0] addr_q,
    output logic          flag_out,
    output logic          addr_ser
);
    logic              busy_q;
    logic [SLOT_W-1:0] slot_q;
    int                step;
    logic              hi_flag, hi_dat, lo_flag, lo_dat;

    // Slot decode: slot 0 is the flag, slots 1..AW carry address MSB first.
    function automatic logic [1:0] slot_bits(input int s, input logic [AW-1:0] a, input logic act);
        logic f, d;
        f = act && (s == 0);
        d = act && (s >= 1) && (s <= LAST_SLOT) ? a[LAST_SLOT - s] : 1'b0;
        return {f, d};
    endfunction

    // Slots consumed per cycle in the captured mode.
    assign step = dual_q ? 2 : 1;

    // Frame state: idle-to-busy on start, slot advance, return to idle after last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dual_q <= 1'b0;
            addr_q <= '0;
            slot_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                dual_q <= dual_in;
                addr_q <= start_addr;
                slot_q <= '0;
            end
        end else if (int'(slot_q) + step > LAST_SLOT) begin
            busy_q <= 1'b0;
        end else begin
            slot_q <= SLOT_W'(int'(slot_q) + step);
        end
    end

    // Line values for the high phase and the low phase of the current cycle.
    always_comb begin
        {hi_flag, hi_dat} = slot_bits(int'(slot_q), addr_q, busy_q);
        {lo_flag, lo_dat} = slot_bits(int'(slot_q) + 1, addr_q, busy_q);
    end

    assign busy     = busy_q;
    assign flag_out = (dual_q && !clk) ? lo_flag : hi_flag;
    assign addr_ser = (dual_q && !clk) ? lo_dat  : hi_dat;
endmodule

// File: rtl/first_hit_serializer.sv
// Module: first_hit_serializer
// Top: samples the channel hit lines, picks the lowest newly-risen channel, and
// serializes flag plus address on the fast clock.
// Assumes hit lines and dual_edge are synchronous to clk_fast.
module first_hit_serializer #(
    parameter int CH = fhs_pkg::CH_COUNT,
    localparam int AW = $clog2(CH)
) (
    input  logic          clk_fast,
    input  logic          rst_n,
    input  logic          dual_edge,
    input  logic [CH-1:0] chan_hit,
    output logic          flag_out,
    output logic          addr_ser
);
    logic [CH-1:0] rise;
    logic          pick_valid;
    logic [AW-1:0] pick_idx;
    logic          busy;
    logic          frame_dual;
    logic [AW-1:0] frame_addr;

    fhs_edge_capture #(.CH(CH)) u_cap (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .hit_in (chan_hit),
        .rise   (rise)
    );

    fhs_first_pick #(.CH(CH)) u_pick (
        .req   (rise),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    fhs_frame_tx #(.AW(AW)) u_tx (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .start      (pick_valid),
        .start_addr (pick_idx),
        .dual_in    (dual_edge),
        .busy       (busy),
        .dual_q     (frame_dual),
        .addr_q     (frame_addr),
        .flag_out   (flag_out),
        .addr_ser   (addr_ser)
    );
endmodule

// File: rtl/fhs_checker.sv
// Module: fhs_checker
// Temporal checks on the serializer, attached to the top through bind.
// Assumes the properties are sampled at the rising edge, so in dual-edge mode they see the high-phase line values.
module fhs_checker #(
    parameter int AW = fhs_pkg::ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          dual_q,
    input logic [AW-1:0] addr_q,
    input logic          pick_valid,
    input logic          flag_out,
    input logic          addr_ser
);
    int busy_cnt;

    // Counts the cycles of the current or just-finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!flag_out && !addr_ser));

    assert_start_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pick_valid));

    assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !dual_q) |-> (busy_cnt == AW + 1));

    assert_flag_first_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dual_q && flag_out) |-> $rose(busy));

    assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && dual_q) |-> (busy_cnt == (AW + 2) / 2));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));
endmodule

bind first_hit_serializer fhs_checker #(.AW(AW)) u_fhs_checker (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .busy       (busy),
    .dual_q     (frame_dual),
    .addr_q     (frame_addr),
    .pick_valid (pick_valid),
    .flag_out   (flag_out),
    .addr_ser   (addr_ser)
);

// File: tb/test_first_hit_serializer.sv
// Bench: directed scenarios, one task each, every task checks its own results.
module test_first_hit_serializer;
    localparam int CLK_PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_edge = 1'b0;
    logic [63:0] hits = '0;
    logic        flag_out, addr_ser;
    int          errors = 0;
    int          checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    first_hit_serializer i_first_hit_serializer (
        .clk_fast  (clk),
        .rst_n     (rst_n),
        .dual_edge (dual_edge),
        .chan_hit  (hits),
        .flag_out  (flag_out),
        .addr_ser  (addr_ser)
    );

    function automatic logic [63:0] ch(input int n);
        return 64'(1) << n;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Raise lines just after an edge; return at edge S+1 (frame start).
    task automatic start_hit(input logic [63:0] v);
        @(posedge clk); #1 hits = hits | v;
        @(posedge clk);
        @(posedge clk);
    endtask

    // Called at a frame's first edge; records slot values at mid-phase.
    task automatic collect(input logic dual, output logic [7:0] fv, output logic [7:0] dv);
        int ncyc;
        ncyc = dual ? 4 : 7;
        fv = '0; dv = '0;
        for (int c = 0; c < ncyc; c++) begin
            if (c > 0) @(posedge clk);
            #2;
            if (dual) begin
                fv[2*c] = flag_out; dv[2*c] = addr_ser;
                #4;
                fv[2*c+1] = flag_out; dv[2*c+1] = addr_ser;
            end else begin
                fv[c] = flag_out; dv[c] = addr_ser;
            end
        end
    endtask

    task automatic check_frame(input logic [7:0] fv, input logic [7:0] dv, input int exp, input string req);
        logic [7:0] edv;
        edv = '0;
        for (int s = 1; s <= 6; s++) edv[s] = exp[6 - s];
        chk(fv == 8'h01, {req, " flag slots"}, 64'(fv), 64'h01);
        chk(dv == edv, {req, " address slots"}, 64'(dv), 64'(edv));
    endtask

    // Both lines low in both phases for n cycles.
    task automatic expect_quiet(input int n, input string req);
        logic bad;
        bad = 1'b0;
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #2;
            if (flag_out || addr_ser) bad = 1'b1;
            #4;
            if (flag_out || addr_ser) bad = 1'b1;
        end
        chk(!bad, {req, " lines quiet"}, 64'(bad), 64'(0));
    endtask

    task automatic settle();
        @(posedge clk); #1 hits = '0;
        repeat (4) @(posedge clk);
    endtask

    // R1: reset state and idle lines.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 chk(!flag_out && !addr_ser, "R1 during reset", 64'({flag_out, addr_ser}), 64'(0));
        @(posedge clk); #1 rst_n = 1'b1;
        expect_quiet(5, "R1 after reset");
    endtask

    // R2/R3/R5/R6: one channel, check exact frame timing and bits.
    task automatic t_one(input int n, input logic dual, input string req);
        logic [7:0] fv, dv;
        dual_edge = dual;
        start_hit(ch(n));
        collect(dual, fv, dv);
        check_frame(fv, dv, n, req);
        @(posedge clk); #2
        chk(!flag_out && !addr_ser, {req, " idle after frame"}, 64'({flag_out, addr_ser}), 64'(0));
        settle();
    endtask

    // R4: simultaneous rises, lowest channel wins.
    task automatic t_lowest(input logic [63:0] v, input int exp, input logic dual);
        logic [7:0] fv, dv;
        dual_edge = dual;
        start_hit(v);
        collect(dual, fv, dv);
        check_frame(fv, dv, exp, "R4 lowest wins");
        settle();
    endtask

    // R7/R8: hit during frame dropped, held lines never retrigger, re-rise does.
    task automatic t_ignore();
        logic [7:0] fv, dv;
        dual_edge = 1'b0;
        start_hit(ch(10));
        fork
            collect(1'b0, fv, dv);
            begin #1 hits = hits | ch(2); end
        join
        check_frame(fv, dv, 10, "R8 address unchanged by busy hit");
        expect_quiet(12, "R7 R8 held and dropped hits");
        settle();
        start_hit(ch(2));
        collect(1'b0, fv, dv);
        check_frame(fv, dv, 2, "R7 re-rise starts frame");
        settle();
    endtask

    // R8/R9: last dropped edge and first accepted edge.
    task automatic t_window(input logic dual);
        logic [7:0] fv, dv;
        int L;
        L = dual ? 4 : 7;
        dual_edge = dual;
        start_hit(ch(5));
        fork
            collect(dual, fv, dv);
            begin
                repeat (L - 2) @(posedge clk);
                #1 hits = hits | ch(9);
                @(posedge clk);
                #1 hits = hits | ch(20);
            end
        join
        check_frame(fv, dv, 5, "R9 first frame");
        @(posedge clk);
        @(posedge clk);
        collect(dual, fv, dv);
        check_frame(fv, dv, 20, "R9 accepted after window");
        expect_quiet(10, "R8 edge S+L dropped");
        settle();
    endtask

    initial begin
        t_reset();
        t_one(0,  1'b0, "R2 R3 R5 ch0 single");
        t_one(63, 1'b0, "R3 R5 ch63 single");
        t_one(37, 1'b0, "R3 R5 ch37 single");
        t_one(42, 1'b1, "R2 R6 ch42 dual");
        t_one(21, 1'b1, "R3 R6 ch21 dual");
        t_lowest(ch(41) | ch(17) | ch(50), 17, 1'b0);
        t_lowest(ch(63) | ch(0), 0, 1'b1);
        t_ignore();
        t_window(1'b0);
        t_window(1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule